// File: doc/BRIEF.md
# Standby Entry and Wakeup Controller

This block sequences a small processor subsystem into and out of a low-power standby state. In normal operation it enables the core clock. A sleep request made while the standby-enable bit is set and the watchdog is stopped gates the clock off. It also drives the two status pins to the standby code and emits a one-cycle strobe that clears the timer start register, unless the realtime clock is in use.

Leaving standby takes time. A wakeup interrupt (non-maskable, external level, or an enabled peripheral source) is accepted regardless of the global block bit. It loads an 8-bit up-counter with a programmed start value and latches the prescaler selection. The clock comes back only when that counter steps from 0xFF to 0x00. The accepted source code is then held for the exception handler, and a wake strobe marks the first running cycle.

A sleep request without the standby conditions enters a light sleep instead. In light sleep the clock is gated but the status pins stay at the normal code. An accepted interrupt resumes operation at once, with no settle count. Either reset input returns the block to the running state on the next edge.

Top module: `stby_ctrl`

## Requirements
- R1: When `sleep_req` is sampled high in the running state with `stby_en`=1 and `wdt_run`=0, the next cycle shows `clk_en`=0 and `status`=2'b01.
- R2: When `sleep_req` is sampled high in the running state with `stby_en`=0, the block enters light sleep: `clk_en`=0 and `status`=2'b00 from the next cycle.
- R3: A sleep request with `stby_en`=1 while `wdt_run`=1 does not enter standby; it enters light sleep as in R2.
- R4: The encoding of `status` (bit 1, bit 0) is 2'b01 for the whole of standby, including the settle count, and 2'b00 in every other state.
- R5: In standby, each of `nmi`, `irl`, or `per_irq` together with `per_irq_en`=1 starts the settle count; `per_irq` with `per_irq_en`=0 does nothing. The start value `cnt_init` and the prescaler select `cks` are captured on the accepting edge, and later changes to them have no effect on that count.
- R6: The clock is restored (`clk_en`=1, `status`=2'b00) exactly 2^(cks+5) × (256 − cnt_init) cycles after the edge that accepted the interrupt. This is the edge on which the 8-bit counter steps from 0xFF to 0x00.
- R7: `blk_mask` has no effect in standby. In light sleep, `blk_mask`=1 blocks `irl` and `per_irq` but never `nmi`.
- R8: `intevt` latches the accepted source on the accepting edge, with codes 1 for `nmi`, 2 for `irl` and 3 for `per_irq`. When several sources are active, `nmi` wins over `irl`, and `irl` wins over `per_irq`. The code is held until the next acceptance and is 0 after reset.
- R9: `tstr_clr` is high for exactly the first standby cycle when `rtc_used`=0, and stays low when `rtc_used`=1 or when light sleep is entered.
- R10: `rst` or `mrst` sampled high returns the block from any state to running on the next cycle, with `intevt`=0 and no strobes.
- R11: `wake_irq` is high for exactly the first running cycle after a settle overflow or a light-sleep exit, and never after a reset.
- R12: In light sleep an accepted interrupt gives `clk_en`=1 in the very next cycle.
- R13: In the running state, interrupts leave `intevt` unchanged. In light sleep and standby, `sleep_req` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| mrst | input | 1 | Manual reset, synchronous, active high |
| stby_en | input | 1 | Standby-enable control bit |
| wdt_run | input | 1 | Watchdog timer-enable bit; must be 0 for standby entry |
| rtc_used | input | 1 | Realtime clock in use; suppresses the timer start clear |
| sleep_req | input | 1 | Sleep request strobe from the core |
| nmi | input | 1 | Non-maskable wakeup interrupt |
| irl | input | 1 | External level wakeup interrupt |
| per_irq | input | 1 | Peripheral wakeup interrupt |
| per_irq_en | input | 1 | Enable for the peripheral wakeup source |
| blk_mask | input | 1 | Global interrupt block bit |
| cnt_init | input | 8 | Settle counter start value |
| cks | input | 3 | Prescaler select, divide by 2^(cks+5) |
| clk_en | output | 1 | Core clock gate enable |
| status | output | 2 | Status pins {status1, status0} |
| intevt | output | 2 | Latched wakeup source code |
| wake_irq | output | 1 | One-cycle wake handoff strobe |
| tstr_clr | output | 1 | One-cycle timer start register clear strobe |

## Verification
The hardest situations to reach from the ports are changes to `cnt_init` or `cks` in the middle of a settle count, and a manual reset arriving partway through it. The settle phase is invisible on the status pins, which read the same as idle standby. The stimulus enters standby and accepts an interrupt with a large start value so that the count is short. It then rewrites the timing inputs several cycles into the count, and in another pass pulses `mrst` before overflow. A behavioural reference that counts the expected wait in plain integers is compared against every output on every cycle.

// File: rtl/stby_pkg.sv
package stby_pkg;

    localparam int CNT_W    = 8;
    localparam int CKS_W    = 3;
    localparam int DIV_BASE = 5;
    localparam int EVT_W    = 2;
    localparam int STAT_W   = 2;

    typedef enum logic [1:0] {
        SQ_RUN    = 2'd0,
        SQ_LIGHT  = 2'd1,
        SQ_STBY   = 2'd2,
        SQ_SETTLE = 2'd3
    } seq_state_t;

    typedef enum logic [EVT_W-1:0] {
        EV_NONE = 2'd0,
        EV_NMI  = 2'd1,
        EV_IRL  = 2'd2,
        EV_PER  = 2'd3
    } wake_src_t;

    typedef struct packed {
        logic nmi;
        logic irl;
        logic per;
    } wake_req_t;

    localparam logic [STAT_W-1:0] STAT_NORMAL  = 2'b00;
    localparam logic [STAT_W-1:0] STAT_STANDBY = 2'b01;

    function automatic wake_src_t pick_src(wake_req_t r);
        if (r.nmi)      return EV_NMI;
        else if (r.irl) return EV_IRL;
        else if (r.per) return EV_PER;
        else            return EV_NONE;
    endfunction

    function automatic logic any_req(wake_req_t r);
        return r.nmi | r.irl | r.per;
    endfunction

endpackage

// File: rtl/stby_prescale.sv
module stby_prescale #(
    parameter int CKS_W    = stby_pkg::CKS_W,
    parameter int DIV_BASE = stby_pkg::DIV_BASE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [CKS_W-1:0] cks,
    output logic             tick
);
    localparam int PRE_W = DIV_BASE + (1 << CKS_W) - 1;

    logic [CKS_W-1:0] sel_q;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = (PRE_W'(1) << (32'(sel_q) + DIV_BASE)) - PRE_W'(1);
        tick = run && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            sel_q <= '0;
        end else if (start) begin
            pre_q <= '0;
            sel_q <= cks;
        end else if (run) begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/stby_settle_cnt.sv
module stby_settle_cnt #(
    parameter int CNT_W = stby_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] init,
    input  logic             tick,
    output logic             ovf
);
    logic [CNT_W-1:0] cnt_q;

    assign ovf = tick && (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (start) cnt_q <= init;
        else if (tick)  cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/stby_seq.sv
module stby_seq
    import stby_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic       stby_ok,
    input  logic       rtc_used,
    input  wake_req_t  req,
    input  logic       blk_mask,
    input  logic       ovf,
    output seq_state_t state_q,
    output logic       start,
    output wake_src_t  evt_q,
    output logic       wake_q,
    output logic       tclr_q
);
    seq_state_t nxt;
    logic       accept;
    wake_src_t  src;
    wake_req_t  light_req;

    always_comb begin
        light_req     = req;
        light_req.irl = req.irl & ~blk_mask;
        light_req.per = req.per & ~blk_mask;
        nxt    = state_q;
        start  = 1'b0;
        accept = 1'b0;
        src    = EV_NONE;
        unique case (state_q)
            SQ_RUN: begin
                if (sleep_req) nxt = stby_ok ? SQ_STBY : SQ_LIGHT;
            end
            SQ_LIGHT: begin
                if (any_req(light_req)) begin
                    nxt    = SQ_RUN;
                    accept = 1'b1;
                    src    = pick_src(light_req);
                end
            end
            SQ_STBY: begin
                if (any_req(req)) begin
                    nxt    = SQ_SETTLE;
                    start  = 1'b1;
                    accept = 1'b1;
                    src    = pick_src(req);
                end
            end
            SQ_SETTLE: begin
                if (ovf) nxt = SQ_RUN;
            end
            default: nxt = SQ_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_RUN;
            evt_q   <= EV_NONE;
            wake_q  <= 1'b0;
            tclr_q  <= 1'b0;
        end else begin
            state_q <= nxt;
            if (accept) evt_q <= src;
            wake_q  <= (state_q == SQ_LIGHT && nxt == SQ_RUN) ||
                       (state_q == SQ_SETTLE && nxt == SQ_RUN);
            tclr_q  <= (state_q == SQ_RUN) && (nxt == SQ_STBY) && !rtc_used;
        end
    end
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int CNT_BITS = stby_pkg::CNT_W,
    parameter int SEL_BITS = stby_pkg::CKS_W,
    parameter int DIV_SHFT = stby_pkg::DIV_BASE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mrst,
    input  logic                stby_en,
    input  logic                wdt_run,
    input  logic                rtc_used,
    input  logic                sleep_req,
    input  logic                nmi,
    input  logic                irl,
    input  logic                per_irq,
    input  logic                per_irq_en,
    input  logic                blk_mask,
    input  logic [CNT_BITS-1:0] cnt_init,
    input  logic [SEL_BITS-1:0] cks,
    output logic                clk_en,
    output logic [STAT_W-1:0]   status,
    output logic [EVT_W-1:0]    intevt,
    output logic                wake_irq,
    output logic                tstr_clr
);
    logic       rst_all;
    wake_req_t  req;
    seq_state_t state;
    wake_src_t  evt;
    logic       start, tick, ovf;
    logic       settling, stby_idle;

    assign rst_all = rst | mrst;
    assign req     = '{nmi: nmi, irl: irl, per: per_irq & per_irq_en};

    stby_seq u_seq (
        .clk      (clk),
        .rst      (rst_all),
        .sleep_req(sleep_req),
        .stby_ok  (stby_en & ~wdt_run),
        .rtc_used (rtc_used),
        .req      (req),
        .blk_mask (blk_mask),
        .ovf      (ovf),
        .state_q  (state),
        .start    (start),
        .evt_q    (evt),
        .wake_q   (wake_irq),
        .tclr_q   (tstr_clr)
    );

    stby_prescale #(.CKS_W(SEL_BITS), .DIV_BASE(DIV_SHFT)) u_pre (
        .clk  (clk),
        .rst  (rst_all),
        .start(start),
        .run  (settling),
        .cks  (cks),
        .tick (tick)
    );

    stby_settle_cnt #(.CNT_W(CNT_BITS)) u_cnt (
        .clk  (clk),
        .rst  (rst_all),
        .start(start),
        .init (cnt_init),
        .tick (tick),
        .ovf  (ovf)
    );

    assign settling  = (state == SQ_SETTLE);
    assign stby_idle = (state == SQ_STBY);
    assign clk_en    = (state == SQ_RUN);
    assign status    = (settling || stby_idle) ? STAT_STANDBY : STAT_NORMAL;
    assign intevt    = evt;
endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       mrst,
    input logic       stby_en,
    input logic       wdt_run,
    input logic       sleep_req,
    input logic       nmi,
    input logic       irl,
    input logic       per_irq,
    input logic       per_irq_en,
    input logic       clk_en,
    input logic [1:0] status,
    input logic [1:0] intevt,
    input logic       wake_irq,
    input logic       tstr_clr,
    input logic       settling,
    input logic       stby_idle
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst | mrst;

    // R10: reset outcome one cycle later
    always_ff @(posedge clk) begin
        if (rst_d) begin
            a_reset_r10: assert (clk_en && status == 2'b00 && intevt == 2'b00 && !wake_irq && !tstr_clr);
        end
    end

    p_entry_r1: assert property (@(posedge clk) disable iff (rst || mrst)
        (clk_en && sleep_req && stby_en && !wdt_run) |=> (!clk_en && status == 2'b01));

    p_light_r2: assert property (@(posedge clk) disable iff (rst || mrst)
        (clk_en && sleep_req && (!stby_en || wdt_run)) |=> (!clk_en && status == 2'b00));

    p_gate_r4: assert property (@(posedge clk) disable iff (rst || mrst)
        (status == 2'b01) |-> !clk_en);

    p_run_code_r4: assert property (@(posedge clk) disable iff (rst || mrst)
        clk_en |-> (status == 2'b00));

    p_mask_ignored_r7: assert property (@(posedge clk) disable iff (rst || mrst)
        (stby_idle && (nmi || irl || (per_irq && per_irq_en))) |=> settling);

    p_light_wake_r12: assert property (@(posedge clk) disable iff (rst || mrst)
        (!clk_en && status == 2'b00 && nmi) |=> clk_en);

    p_handoff_r11: assert property (@(posedge clk) disable iff (rst || mrst)
        wake_irq |-> (clk_en && $past(!clk_en)));

    p_tstr_r9: assert property (@(posedge clk) disable iff (rst || mrst)
        tstr_clr |-> (stby_idle && $past(clk_en)));
endmodule

bind stby_ctrl stby_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mrst      (mrst),
    .stby_en   (stby_en),
    .wdt_run   (wdt_run),
    .sleep_req (sleep_req),
    .nmi       (nmi),
    .irl       (irl),
    .per_irq   (per_irq),
    .per_irq_en(per_irq_en),
    .clk_en    (clk_en),
    .status    (status),
    .intevt    (intevt),
    .wake_irq  (wake_irq),
    .tstr_clr  (tstr_clr),
    .settling  (settling),
    .stby_idle (stby_idle)
);

// File: tb/stby_ctrl_tb_top.sv
`timescale 1ns/1ps
module stby_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1, mrst = 1'b0;
    logic stby_en = 0, wdt_run = 0, rtc_used = 0, sleep_req = 0;
    logic nmi = 0, irl = 0, per_irq = 0, per_irq_en = 0, blk_mask = 0;
    logic [7:0] cnt_init = 8'hFE;
    logic [2:0] cks = 3'd0;
    logic       clk_en, wake_irq, tstr_clr;
    logic [1:0] status, intevt;

    int vectors = 0, errors = 0, cycles = 0;
    string cur_req = "R10";

    always #5 clk = ~clk;

    stby_ctrl dut_i (
        .clk(clk), .rst(rst), .mrst(mrst), .stby_en(stby_en), .wdt_run(wdt_run),
        .rtc_used(rtc_used), .sleep_req(sleep_req), .nmi(nmi), .irl(irl),
        .per_irq(per_irq), .per_irq_en(per_irq_en), .blk_mask(blk_mask),
        .cnt_init(cnt_init), .cks(cks), .clk_en(clk_en), .status(status),
        .intevt(intevt), .wake_irq(wake_irq), .tstr_clr(tstr_clr)
    );

    // behavioural reference: 0 run, 1 light, 2 standby idle, 3 settling
    int         ms = 0;
    int         wait_left = 0;
    logic [1:0] m_evt = 0;
    logic       m_wake = 0, m_tclr = 0;

    function automatic logic [1:0] code_of(logic a, logic b, logic c);
        if (a) return 2'd1;
        if (b) return 2'd2;
        if (c) return 2'd3;
        return 2'd0;
    endfunction

    always @(posedge clk) begin
        logic pe;
        pe = per_irq && per_irq_en;
        if (rst || mrst) begin
            ms = 0; m_evt = 0; m_wake = 0; m_tclr = 0;
        end else begin
            m_wake = 0; m_tclr = 0;
            case (ms)
                0: if (sleep_req) begin
                       if (stby_en && !wdt_run) begin ms = 2; m_tclr = !rtc_used; end
                       else ms = 1;
                   end
                1: if (nmi || (!blk_mask && (irl || pe))) begin
                       m_evt = code_of(nmi, irl && !blk_mask, pe && !blk_mask);
                       ms = 0; m_wake = 1;
                   end
                2: if (nmi || irl || pe) begin
                       m_evt = code_of(nmi, irl, pe);
                       wait_left = (1 << (int'(cks) + 5)) * (256 - int'(cnt_init));
                       ms = 3;
                   end
                default: begin
                    wait_left--;
                    if (wait_left == 0) begin ms = 0; m_wake = 1; end
                end
            endcase
        end
    end

    task automatic cmp(string what, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", cur_req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 2) begin
            cmp("clk_en", 8'(clk_en), 8'(ms == 0));
            cmp("status R4", 8'(status), (ms >= 2) ? 8'h01 : 8'h00);
            cmp("intevt R8", 8'(intevt), 8'(m_evt));
            cmp("wake_irq R11", 8'(wake_irq), 8'(m_wake));
            cmp("tstr_clr R9", 8'(tstr_clr), 8'(m_tclr));
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sleep_pulse();
        sleep_req = 1; step(1); sleep_req = 0; step(1);
    endtask

    task automatic point(string req, logic [7:0] act, logic [7:0] exp);
        string keep;
        keep = cur_req; cur_req = req;
        cmp("point", act, exp);
        cur_req = keep;
    endtask

    task automatic wait_run(int lim);
        for (int i = 0; i < lim && !clk_en; i++) step(1);
    endtask

    initial begin
        step(3);
        rst = 0;
        step(1);
        point("R10", {clk_en, status, intevt}, 8'b1_00_00);

        cur_req = "R13";
        nmi = 1; irl = 1; step(2); nmi = 0; irl = 0; step(1);
        point("R13", 8'(intevt), 8'd0);

        cur_req = "R2";
        sleep_pulse();
        point("R2", {clk_en, status}, 8'b0_00);
        step(2);
        cur_req = "R13";
        sleep_req = 1; step(1); sleep_req = 0; step(1);
        point("R13", {clk_en, status}, 8'b0_00);
        cur_req = "R12";
        irl = 1; step(1); irl = 0;
        point("R12", 8'(clk_en), 8'd1);
        point("R11", 8'(wake_irq), 8'd1);
        point("R8", 8'(intevt), 8'd2);
        step(2);

        cur_req = "R7";
        sleep_pulse();
        blk_mask = 1; irl = 1; per_irq = 1; per_irq_en = 1; step(4);
        point("R7", 8'(clk_en), 8'd0);
        nmi = 1; step(1); nmi = 0; irl = 0; per_irq = 0; blk_mask = 0;
        point("R7", {clk_en, intevt}, 8'b1_01);
        step(2);

        cur_req = "R3";
        stby_en = 1; wdt_run = 1;
        sleep_pulse();
        point("R3", {clk_en, status}, 8'b0_00);
        per_irq = 1; step(1); per_irq = 0;
        point("R8", {clk_en, intevt}, 8'b1_11);
        wdt_run = 0; per_irq_en = 0; step(2);

        cur_req = "R1";
        rtc_used = 0; cnt_init = 8'hFE; cks = 3'd0;
        sleep_req = 1; step(1); sleep_req = 0;
        point("R1", {clk_en, status}, 8'b0_01);
        point("R9", 8'(tstr_clr), 8'd1);
        step(1);
        point("R9", 8'(tstr_clr), 8'd0);
        cur_req = "R5";
        per_irq = 1; step(3); per_irq = 0;
        point("R5", 8'(status), 8'h01);
        cur_req = "R7";
        blk_mask = 1; irl = 1; step(1); irl = 0;
        cur_req = "R5";
        step(5); cks = 3'd4; cnt_init = 8'h00;
        cur_req = "R6";
        step(40);
        point("R6", 8'(clk_en), 8'd0);
        wait_run(100);
        point("R6", {clk_en, status}, 8'b1_00);
        blk_mask = 0; step(2);

        cur_req = "R9";
        rtc_used = 1; cks = 3'd2; cnt_init = 8'hFD;
        sleep_req = 1; step(1); sleep_req = 0;
        point("R9", 8'(tstr_clr), 8'd0);
        step(2);
        nmi = 1; irl = 1; step(1); nmi = 0; irl = 0;
        point("R8", 8'(intevt), 8'd1);
        cur_req = "R13";
        sleep_req = 1; step(1); sleep_req = 0;
        cur_req = "R6";
        wait_run(600);
        point("R6", 8'(clk_en), 8'd1);
        step(2);

        cur_req = "R10";
        rtc_used = 0; cnt_init = 8'hF0; cks = 3'd1;
        sleep_pulse();
        irl = 1; step(1); irl = 0; step(20);
        mrst = 1; step(1); mrst = 0;
        point("R10", {clk_en, status, intevt, wake_irq}, 8'b1_00_00_0);
        step(2);
        sleep_pulse();
        rst = 1; step(1); rst = 0;
        point("R10", {clk_en, status}, 8'b1_00);
        step(2);

        cur_req = "R6";
        cnt_init = 8'hFF; cks = 3'd7;
        sleep_pulse();
        nmi = 1; step(1); nmi = 0;
        wait_run(5000);
        point("R6", 8'(clk_en), 8'd1);
        step(3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule